// File: doc/BRIEF.md
# UART Receive Byte Queue with Interrupt Events

This block sits behind a UART deserializer. It collects received bytes in a 128-entry first-in first-out queue, and software drains the queue through a read port. The block raises three interrupt sources: a fill-level event when the number of stored bytes reaches a programmable mark, an idle timeout event when the receive line has been quiet for a programmable number of bit periods while unread bytes remain below that mark, and an overflow event when a byte arrives and there is no room for it.

A configuration strobe loads the fill mark, the timeout length in bit periods, the timeout enable and the three per-source interrupt enables. The status bits are sticky. Software clears them by writing ones to a clear mask. A flush command discards the queue contents at once. The block drives the raw status, the enabled (masked) status, one level interrupt line and the current fill count.

Status bit positions are fixed: bit 0 is the fill-level event, bit 1 is the idle timeout and bit 2 is the overflow.

Top module: `uart_rx_fifo_irq`

## Requirements
- R1: The queue holds up to 128 bytes and returns them in arrival order. `rd_data` shows the oldest stored byte, and a cycle with `rd_en` high while the queue is not empty removes that byte.
- R2: Status bit 0 becomes set one cycle after `fill_level` is at or above the fill mark. After reset the fill mark is 120, so 119 stored bytes leave the bit clear and 120 set it.
- R3: Status bit 1 becomes set on the clock edge that samples the Nth `bit_tick`, where N is the timeout length. The ticks must be counted while `line_idle` is high and the queue is non-empty, with no received byte in between. The bit is set only if `fill_level` is below the fill mark at that edge. After reset the timeout length is 10 and the timeout is enabled. An empty queue or a busy line produces no timeout.
- R4: While the timeout enable is 0, status bit 1 is never set.
- R5: One idle period produces at most one timeout event. Further ticks after the event do not set the bit again. Any received byte restarts the idle count.
- R6: A byte that arrives while the queue holds 128 bytes is discarded. It sets status bit 2 on that edge, and the 128 stored bytes stay unchanged.
- R7: A cycle with `clr_we` high clears every status bit whose `clr_mask` bit is 1 and leaves the others unchanged. On that edge a clear takes priority over any new event for the same bit.
- R8: If the fill level is still at or above the fill mark after bit 0 is cleared, bit 0 is set again on the following clock.
- R9: `stat_masked` is `stat_raw` ANDed with the interrupt enables, which reset to 0. `irq` is the OR of `stat_masked` and stays high until the contributing bits are cleared or disabled.
- R10: `flush` empties the queue and resets both pointers on the next edge. A byte offered in the same cycle is dropped.
- R11: After reset, `fill_level`, `stat_raw`, `stat_masked` and `irq` are all 0. A read of an empty queue changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Received-byte strobe from the deserializer |
| rx_data | input | 8 | Received byte |
| bit_tick | input | 1 | One pulse per bit period |
| line_idle | input | 1 | Receive line is idle |
| cfg_we | input | 1 | Load all configuration fields |
| cfg_full_thr | input | 8 | Fill mark in bytes |
| cfg_tout_len | input | 8 | Idle timeout in bit periods |
| cfg_tout_en | input | 1 | Timeout enable |
| cfg_irq_en | input | 3 | Per-source interrupt enables |
| rd_en | input | 1 | Pop the oldest byte |
| rd_data | output | 8 | Oldest stored byte |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 3 | Write-one-to-clear mask |
| flush | input | 1 | Empty the queue |
| stat_raw | output | 3 | Sticky raw status |
| stat_masked | output | 3 | Raw status ANDed with the enables |
| irq | output | 1 | Combined interrupt level |
| fill_level | output | 8 | Number of stored bytes |

## Verification
The assertions assume that `rx_valid`, `rd_en`, `flush` and `clr_we` are clean single-cycle-per-event strobes that only change between clock edges. They also assume `fill_level` is driven only by the queue's own push and pop decisions. The stimulus meets these assumptions. Every input is driven on the falling edge and held for exactly one cycle per operation, so no strobe overlaps another unless a test intends it. The one deliberate overlap, a flush in the same cycle as a received byte, is applied where the expected result is an empty queue.

// File: rtl/uart_rxq_pkg.sv
// Shared constants for the receive queue: status bit positions and count.
package uart_rxq_pkg;
    localparam int ST_FULL = 0;
    localparam int ST_TOUT = 1;
    localparam int ST_OVF  = 2;
    localparam int ST_W    = 3;
endpackage

// File: rtl/rxq_store.sv
// Byte queue storage with read/write pointers and an occupancy count.
// Assumes at most one push and one pop per cycle; flush beats both.
module rxq_store #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              ovf_evt
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp_q, rp_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              full, empty, do_wr, do_rd;

    // Decode accepted push/pop and the overflow event.
    always_comb begin
        full    = (cnt_q == CNT_W'(DEPTH));
        empty   = (cnt_q == '0);
        do_wr   = wr_req && !full && !flush;
        do_rd   = rd_req && !empty && !flush;
        ovf_evt = wr_req && full && !flush;
    end

    // Store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp_q] <= wr_data;
    end

    // Advance pointers and count; flush returns everything to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_wr) wp_q <= (wp_q == PTR_W'(DEPTH-1)) ? '0 : wp_q + 1'b1;
            if (do_rd) rp_q <= (rp_q == PTR_W'(DEPTH-1)) ? '0 : rp_q + 1'b1;
            unique case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign rd_data = mem[rp_q];
    assign count   = cnt_q;
endmodule

// File: rtl/rxq_idle_timer.sv
// Counts bit periods of idle line while bytes wait; emits one event per
// idle period. Assumes bit_tick is a single-cycle pulse.
module rxq_idle_timer #(
    parameter int TOUT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              bit_tick,
    input  logic              line_idle,
    input  logic              nonempty,
    input  logic              enable,
    input  logic              below_thr,
    input  logic [TOUT_W-1:0] limit,
    output logic              tout_evt
);
    logic [TOUT_W:0] cnt_q, cnt_inc;
    logic            fired_q, step, hit, hold_off;

    // Qualify a counting step and compare against the limit.
    always_comb begin
        hold_off = restart || !line_idle || !nonempty;
        step     = bit_tick && !fired_q && !hold_off;
        cnt_inc  = cnt_q + 1'b1;
        hit      = (cnt_inc >= {1'b0, limit});
        tout_evt = step && hit && enable && below_thr;
    end

    // Idle count and once-per-period latch.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_off) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
        end else if (step) begin
            cnt_q <= cnt_inc;
            if (hit) fired_q <= 1'b1;
        end
    end
endmodule

// File: rtl/rxq_status.sv
// Sticky status bits with write-one-to-clear, masking and a combined line.
// Assumes a clear wins over an event on the same edge.
module rxq_status #(
    parameter int ST_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] evt,
    input  logic            clr_we,
    input  logic [ST_W-1:0] clr_mask,
    input  logic [ST_W-1:0] irq_en,
    output logic [ST_W-1:0] raw,
    output logic [ST_W-1:0] masked,
    output logic            irq
);
    for (genvar i = 0; i < ST_W; i++) begin : g_bit
        logic bit_q;
        // Set on event, clear on a one in the clear mask.
        always_ff @(posedge clk) begin
            if (!rst_n)                    bit_q <= 1'b0;
            else if (clr_we && clr_mask[i]) bit_q <= 1'b0;
            else if (evt[i])               bit_q <= 1'b1;
        end
        assign raw[i] = bit_q;
    end

    assign masked = raw & irq_en;
    assign irq    = |masked;
endmodule

// File: rtl/uart_rx_fifo_irq.sv
// Receive queue top: configuration registers plus queue, idle timer and
// status. Assumes rx_valid, rd_en, flush and strobes are synchronous.
module uart_rx_fifo_irq
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH    = 128,
    parameter int DATA_W   = 8,
    parameter int TOUT_W   = 8,
    parameter int THR_RST  = 120,
    parameter int TOUT_RST = 10,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              bit_tick,
    input  logic              line_idle,
    input  logic              cfg_we,
    input  logic [CNT_W-1:0]  cfg_full_thr,
    input  logic [TOUT_W-1:0] cfg_tout_len,
    input  logic              cfg_tout_en,
    input  logic [ST_W-1:0]   cfg_irq_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              clr_we,
    input  logic [ST_W-1:0]   clr_mask,
    input  logic              flush,
    output logic [ST_W-1:0]   stat_raw,
    output logic [ST_W-1:0]   stat_masked,
    output logic              irq,
    output logic [CNT_W-1:0]  fill_level
);
    logic [CNT_W-1:0]  thr_q;
    logic [TOUT_W-1:0] tout_q;
    logic              tout_en_q;
    logic [ST_W-1:0]   irq_en_q;
    logic [CNT_W-1:0]  count;
    logic              ovf_evt, tout_evt;
    logic [ST_W-1:0]   evt;

    // Configuration registers with their reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q     <= CNT_W'(THR_RST);
            tout_q    <= TOUT_W'(TOUT_RST);
            tout_en_q <= 1'b1;
            irq_en_q  <= '0;
        end else if (cfg_we) begin
            thr_q     <= cfg_full_thr;
            tout_q    <= cfg_tout_len;
            tout_en_q <= cfg_tout_en;
            irq_en_q  <= cfg_irq_en;
        end
    end

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_req(rx_valid), .wr_data(rx_data), .rd_req(rd_en),
        .rd_data(rd_data), .count(count), .ovf_evt(ovf_evt)
    );

    rxq_idle_timer #(.TOUT_W(TOUT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(rx_valid || flush),
        .bit_tick(bit_tick), .line_idle(line_idle),
        .nonempty(count != '0), .enable(tout_en_q),
        .below_thr(count < thr_q), .limit(tout_q), .tout_evt(tout_evt)
    );

    // Gather the event sources into status bit order.
    always_comb begin
        evt          = '0;
        evt[ST_FULL] = (count >= thr_q);
        evt[ST_TOUT] = tout_evt;
        evt[ST_OVF]  = ovf_evt;
    end

    rxq_status #(.ST_W(ST_W)) u_status (
        .clk(clk), .rst_n(rst_n), .evt(evt), .clr_we(clr_we),
        .clr_mask(clr_mask), .irq_en(irq_en_q),
        .raw(stat_raw), .masked(stat_masked), .irq(irq)
    );

    assign fill_level = count;
endmodule

// File: rtl/rxq_checker.sv
// Temporal checks on the receive queue ports; bound into the top module.
module rxq_checker
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             rd_en,
    input logic             flush,
    input logic             clr_we,
    input logic [ST_W-1:0]  clr_mask,
    input logic [CNT_W-1:0] fill_level,
    input logic [ST_W-1:0]  stat_raw,
    input logic [ST_W-1:0]  stat_masked,
    input logic             irq
);
    // R1
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= CNT_W'(DEPTH));

    // R6
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && fill_level == CNT_W'(DEPTH) && !flush && !clr_we |=> stat_raw[ST_OVF]);

    // R6
    ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && fill_level == CNT_W'(DEPTH) && !rd_en && !flush |=> fill_level == CNT_W'(DEPTH));

    // R7
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> (stat_raw & $past(clr_mask)) == '0);

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> fill_level == '0);

    // R9
    mask_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_masked & ~stat_raw) == '0 && (irq == (stat_masked != '0)));

    // R11
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level == '0 && rd_en && !rx_valid |=> fill_level == '0);
endmodule

bind uart_rx_fifo_irq rxq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rd_en(rd_en),
    .flush(flush), .clr_we(clr_we), .clr_mask(clr_mask),
    .fill_level(fill_level), .stat_raw(stat_raw),
    .stat_masked(stat_masked), .irq(irq)
);

// File: tb/uart_rx_fifo_irq_bench.sv
`timescale 1ns/1ps
module uart_rx_fifo_irq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       bit_tick = 1'b0;
    logic       line_idle = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_full_thr = '0;
    logic [7:0] cfg_tout_len = '0;
    logic       cfg_tout_en = 1'b0;
    logic [2:0] cfg_irq_en = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       clr_we = 1'b0;
    logic [2:0] clr_mask = '0;
    logic       flush = 1'b0;
    logic [2:0] stat_raw, stat_masked;
    logic       irq;
    logic [7:0] fill_level;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_rx_fifo_irq u_uart_rx_fifo_irq (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .bit_tick(bit_tick), .line_idle(line_idle), .cfg_we(cfg_we),
        .cfg_full_thr(cfg_full_thr), .cfg_tout_len(cfg_tout_len),
        .cfg_tout_en(cfg_tout_en), .cfg_irq_en(cfg_irq_en), .rd_en(rd_en),
        .rd_data(rd_data), .clr_we(clr_we), .clr_mask(clr_mask),
        .flush(flush), .stat_raw(stat_raw), .stat_masked(stat_masked),
        .irq(irq), .fill_level(fill_level)
    );

    // push count, pop count, expected fill, expected bit 0 (fill mark 5)
    localparam logic [24:0] VEC [7] = '{
        {8'd0, 8'd0, 8'd0, 1'b0},
        {8'd3, 8'd0, 8'd3, 1'b0},
        {8'd4, 8'd0, 8'd4, 1'b0},
        {8'd5, 8'd0, 8'd5, 1'b1},
        {8'd7, 8'd2, 8'd5, 1'b1},
        {8'd6, 8'd2, 8'd4, 1'b1},
        {8'd4, 8'd4, 8'd0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk); bit_tick = 1'b1;
            @(negedge clk); bit_tick = 1'b0;
        end
    endtask

    task automatic clear(input logic [2:0] m);
        @(negedge clk); clr_we = 1'b1; clr_mask = m;
        @(negedge clk); clr_we = 1'b0; clr_mask = '0;
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic cfg(input logic [7:0] thr, input logic [7:0] tl, input logic en, input logic [2:0] ie);
        @(negedge clk); cfg_we = 1'b1; cfg_full_thr = thr; cfg_tout_len = tl;
        cfg_tout_en = en; cfg_irq_en = ie;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic fresh();
        do_flush();
        clear(3'b111);
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int bad;
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        idle(1);
        // R11 reset state
        chk("R11 reset fill", fill_level, 0);
        chk("R11 reset raw", stat_raw, 0);
        chk("R11 reset irq", {stat_masked, irq}, 0);

        // R3 default timeout of 10 bit periods
        push(8'h11);
        ticks(9);
        chk("R3 default tout at 9", stat_raw[1], 0);
        ticks(1);
        chk("R3 default tout at 10", stat_raw[1], 1);
        fresh();

        // R2 default fill mark 120, R1 capacity and order, R6 overflow
        for (int i = 0; i < 119; i++) push(8'(i));
        idle(1);
        chk("R2 default mark at 119", stat_raw[0], 0);
        push(8'd119);
        idle(1);
        chk("R2 default mark at 120", stat_raw[0], 1);
        for (int i = 120; i < 128; i++) push(8'(i));
        chk("R1 capacity 128", fill_level, 128);
        chk("R6 no overflow yet", stat_raw[2], 0);
        push(8'hEE);
        chk("R6 overflow flag", stat_raw[2], 1);
        chk("R6 fill kept", fill_level, 128);
        bad = 0;
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            if (rd_data !== 8'(i)) bad++;
            pop();
        end
        chk("R1 R6 order and contents", bad, 0);
        chk("R1 drained", fill_level, 0);
        fresh();

        // R2 table walk with fill mark 5
        cfg(8'd5, 8'd10, 1'b1, 3'b000);
        for (int v = 0; v < 7; v++) begin
            fresh();
            for (int p = 0; p < int'(VEC[v][24:17]); p++) push(8'(p));
            for (int q = 0; q < int'(VEC[v][16:9]); q++) pop();
            idle(1);
            chk("R2 table fill", fill_level, VEC[v][8:1]);
            chk("R2 table bit0", stat_raw[0], VEC[v][0]);
        end

        // R7 and R8: clear-zero keeps, clear re-asserts while above mark
        cfg(8'd2, 8'd3, 1'b1, 3'b000);
        fresh();
        push(8'd1); push(8'd2); push(8'd3);
        idle(1);
        chk("R2 bit0 at mark 2", stat_raw[0], 1);
        clear(3'b000);
        chk("R7 zero mask keeps", stat_raw[0], 1);
        clear(3'b001);
        chk("R7 cleared", stat_raw[0], 0);
        idle(1);
        chk("R8 re-set above mark", stat_raw[0], 1);

        // R3 no timeout at or above mark
        ticks(4);
        chk("R3 above mark no tout", stat_raw[1], 0);

        // R9 masking and level interrupt
        cfg(8'd2, 8'd3, 1'b1, 3'b010);
        chk("R9 masked off", {stat_masked, irq}, 0);
        cfg(8'd2, 8'd3, 1'b1, 3'b001);
        chk("R9 masked on", {stat_masked, irq}, 4'b0011);
        idle(3);
        chk("R9 level held", irq, 1);
        pop(); pop();
        clear(3'b001);
        idle(2);
        chk("R9 irq after clear", irq, 0);

        // R5 single event per idle period, restart on byte
        cfg(8'd120, 8'd3, 1'b1, 3'b000);
        fresh();
        push(8'd5); push(8'd6);
        ticks(3);
        chk("R5 first tout", stat_raw[1], 1);
        clear(3'b010);
        ticks(5);
        chk("R5 no second tout", stat_raw[1], 0);
        push(8'd7);
        ticks(2);
        chk("R5 restart partial", stat_raw[1], 0);
        ticks(1);
        chk("R5 restart full", stat_raw[1], 1);

        // R3 empty queue and busy line give no timeout
        fresh();
        ticks(5);
        chk("R3 empty no tout", stat_raw[1], 0);
        push(8'd8);
        line_idle = 1'b0;
        ticks(5);
        chk("R3 busy line no tout", stat_raw[1], 0);
        line_idle = 1'b1;

        // R4 timeout disabled
        cfg(8'd120, 8'd3, 1'b0, 3'b000);
        fresh();
        push(8'd9);
        ticks(6);
        chk("R4 disabled no tout", stat_raw[1], 0);

        // R10 flush, including a byte in the same cycle
        push(8'd1); push(8'd2);
        do_flush();
        chk("R10 flush empties", fill_level, 0);
        push(8'hA5);
        chk("R10 fresh head", rd_data, 8'hA5);
        @(negedge clk); flush = 1'b1; rx_valid = 1'b1; rx_data = 8'h77;
        @(negedge clk); flush = 1'b0; rx_valid = 1'b0;
        chk("R10 byte with flush dropped", fill_level, 0);

        // R11 read of empty queue
        pop();
        chk("R11 empty read", fill_level, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule